// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 16-bit buses, called A and B, and moves data from one to the other, either straight through or out of a storage register. It is split into two 8-bit halves that share nothing but the system clock and reset. Each half has its own output enable, direction, pair of source selects and pair of capture strobes. With all controls of both halves tied together, it acts as a single 16-bit transceiver.

Each half holds two registers. The A-to-B register takes A-side data on a rising edge of its capture strobe. The B-to-A register takes B-side data on a rising edge of its own strobe. When the outputs are enabled, the direction input picks which bus is driven. The select for that direction then chooses between the live word from the opposite bus and the stored word. While the outputs are disabled (isolation), neither bus is driven, but both registers keep capturing.

The pins are modelled as separate input, output and output-enable signals, and no tri-state logic is used. The capture strobes are not treated as clocks. They are sampled in the system clock domain and edge-detected.

Top module: `bxcv_top`

## Requirements
- R1: A synchronous active-high `rst` clears both storage registers of both halves to zero. The cleared value is visible through the stored path on the first cycle after reset is released.
- R2: While `oe_n[h]` is 1, half h drives neither bus. Both `a_oe[h]` and `b_oe[h]` are 0, and the output bits of half h on both buses are 0.
- R3: While `oe_n[h]` is 0, setting `dir[h]` to 1 enables B only (`b_oe[h]`=1) and setting it to 0 enables A only (`a_oe[h]`=1). The two enables of a half are never 1 together.
- R4: With B enabled and `sel_ab[h]`=0, the B output of half h equals the A input of half h in the same cycle (live path). The same holds for A with `sel_ba[h]`=0 and the B input.
- R5: With B enabled and `sel_ab[h]`=1, the B output of half h equals the A-to-B register. With A enabled and `sel_ba[h]`=1, the A output equals the B-to-A register.
- R6: A capture happens in a cycle where `tick_ab[h]` is 1 after being 0 in the previous cycle. The A-to-B register of half h then loads that cycle's A input, and the new value is visible from the next cycle. `tick_ba[h]` loads the B input into the B-to-A register in the same way.
- R7: A strobe that stays high, stays low or falls causes no capture. A strobe held high through the release of reset also causes no capture.
- R8: Captures take place whether half h is isolated, driving A or driving B.
- R9: Half h owns bus bits [8h+7:8h] and control bit h. The controls of one half have no effect on the outputs or registers of the other half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oe_n | input | 2 | Per-half output enable, active low |
| dir | input | 2 | Per-half direction: 1 drives B, 0 drives A |
| sel_ab | input | 2 | Per-half B source: 0 live A, 1 stored |
| sel_ba | input | 2 | Per-half A source: 0 live B, 1 stored |
| tick_ab | input | 2 | Per-half capture strobe for the A-to-B register |
| tick_ba | input | 2 | Per-half capture strobe for the B-to-A register |
| a_in | input | 16 | A bus input |
| a_out | output | 16 | A bus output value |
| a_oe | output | 2 | Per-half A drive enable |
| b_in | input | 16 | B bus input |
| b_out | output | 16 | B bus output value |
| b_oe | output | 2 | Per-half B drive enable |

## Verification
The hardest case to reach is a register that was loaded while nothing could show it. This happens during isolation, or while the opposite bus is being driven. The register can only be observed after the controls have been changed to make its stored path visible. The stimulus fires both strobes of a half while that half is isolated, and changes the input buses afterwards. It then enables each direction in turn with the stored path selected. A strobe held high across reset release is also included, and it must leave the cleared value in place.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'd0,
        DRV_TO_A = 2'd1,
        DRV_TO_B = 2'd2
    } drive_e;

    typedef struct packed {
        logic oe_n;
        logic dir;
        logic sel_ab;
        logic sel_ba;
        logic tick_ab;
        logic tick_ba;
    } half_ctl_t;

    function automatic drive_e decode_drive(input logic oe_n, input logic dir);
        if (oe_n)
            return DRV_NONE;
        else if (dir)
            return DRV_TO_B;
        else
            return DRV_TO_A;
    endfunction

endpackage

// File: rtl/bxcv_rise.sv
module bxcv_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] smp,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev;

    // previous sample tracks the strobe even during reset
    always_ff @(posedge clk) begin
        prev <= smp;
    end

    assign rise = smp & ~prev;
endmodule

// File: rtl/bxcv_store.sv
module bxcv_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/bxcv_half.sv
module bxcv_half
    import bxcv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  half_ctl_t    ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    output logic [W-1:0] st_ab,
    output logic [W-1:0] st_ba
);
    localparam int N_STROBES = 2;

    logic [N_STROBES-1:0] rise;
    drive_e               drv;

    bxcv_rise #(.N(N_STROBES)) u_rise (
        .clk  (clk),
        .smp  ({ctl.tick_ba, ctl.tick_ab}),
        .rise (rise)
    );

    bxcv_store #(.W(W)) u_st_ab (
        .clk  (clk),
        .rst  (rst),
        .load (rise[0]),
        .d    (a_in),
        .q    (st_ab)
    );

    bxcv_store #(.W(W)) u_st_ba (
        .clk  (clk),
        .rst  (rst),
        .load (rise[1]),
        .d    (b_in),
        .q    (st_ba)
    );

    always_comb begin
        drv   = decode_drive(ctl.oe_n, ctl.dir);
        b_oe  = (drv == DRV_TO_B);
        a_oe  = (drv == DRV_TO_A);
        b_out = '0;
        a_out = '0;
        if (b_oe)
            b_out = ctl.sel_ab ? st_ab : a_in;
        if (a_oe)
            a_out = ctl.sel_ba ? st_ba : b_in;
    end
endmodule

// File: rtl/bxcv_top.sv
module bxcv_top
    import bxcv_pkg::*;
#(
    parameter  int HALF_W   = 8,
    parameter  int N_HALVES = 2,
    localparam int BUS_W    = HALF_W * N_HALVES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_HALVES-1:0] oe_n,
    input  logic [N_HALVES-1:0] dir,
    input  logic [N_HALVES-1:0] sel_ab,
    input  logic [N_HALVES-1:0] sel_ba,
    input  logic [N_HALVES-1:0] tick_ab,
    input  logic [N_HALVES-1:0] tick_ba,
    input  logic [BUS_W-1:0]    a_in,
    output logic [BUS_W-1:0]    a_out,
    output logic [N_HALVES-1:0] a_oe,
    input  logic [BUS_W-1:0]    b_in,
    output logic [BUS_W-1:0]    b_out,
    output logic [N_HALVES-1:0] b_oe
);
    logic [BUS_W-1:0] st_ab;
    logic [BUS_W-1:0] st_ba;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        half_ctl_t ctl;
        assign ctl = '{oe_n: oe_n[h], dir: dir[h], sel_ab: sel_ab[h],
                       sel_ba: sel_ba[h], tick_ab: tick_ab[h], tick_ba: tick_ba[h]};

        bxcv_half #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .a_in  (a_in[h*HALF_W +: HALF_W]),
            .b_in  (b_in[h*HALF_W +: HALF_W]),
            .a_out (a_out[h*HALF_W +: HALF_W]),
            .a_oe  (a_oe[h]),
            .b_out (b_out[h*HALF_W +: HALF_W]),
            .b_oe  (b_oe[h]),
            .st_ab (st_ab[h*HALF_W +: HALF_W]),
            .st_ba (st_ba[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: rtl/bxcv_checker.sv
module bxcv_checker #(
    parameter  int HALF_W   = 8,
    parameter  int N_HALVES = 2,
    localparam int BUS_W    = HALF_W * N_HALVES
) (
    input logic                clk,
    input logic                rst,
    input logic [N_HALVES-1:0] oe_n,
    input logic [N_HALVES-1:0] sel_ab,
    input logic [N_HALVES-1:0] sel_ba,
    input logic [N_HALVES-1:0] tick_ab,
    input logic [N_HALVES-1:0] tick_ba,
    input logic [BUS_W-1:0]    a_in,
    input logic [BUS_W-1:0]    b_in,
    input logic [BUS_W-1:0]    a_out,
    input logic [N_HALVES-1:0] a_oe,
    input logic [BUS_W-1:0]    b_out,
    input logic [N_HALVES-1:0] b_oe,
    input logic [BUS_W-1:0]    st_ab,
    input logic [BUS_W-1:0]    st_ba
);
    for (genvar h = 0; h < N_HALVES; h++) begin : g_chk
        p_isolate_r2: assert property (@(posedge clk) disable iff (rst)
            oe_n[h] |-> (!a_oe[h] && !b_oe[h] &&
                         a_out[h*HALF_W +: HALF_W] == '0 && b_out[h*HALF_W +: HALF_W] == '0));

        p_one_side_r3: assert property (@(posedge clk) disable iff (rst)
            $countones({a_oe[h], b_oe[h]}) <= 1);

        p_live_b_r4: assert property (@(posedge clk) disable iff (rst)
            (b_oe[h] && !sel_ab[h]) |-> b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]);

        p_live_a_r4: assert property (@(posedge clk) disable iff (rst)
            (a_oe[h] && !sel_ba[h]) |-> a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]);

        p_stored_b_r5: assert property (@(posedge clk) disable iff (rst)
            (b_oe[h] && sel_ab[h]) |-> b_out[h*HALF_W +: HALF_W] == st_ab[h*HALF_W +: HALF_W]);

        p_stored_a_r5: assert property (@(posedge clk) disable iff (rst)
            (a_oe[h] && sel_ba[h]) |-> a_out[h*HALF_W +: HALF_W] == st_ba[h*HALF_W +: HALF_W]);

        p_cap_ab_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(tick_ab[h]) |=> st_ab[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));

        p_cap_ba_r6: assert property (@(posedge clk) disable iff (rst)
            $rose(tick_ba[h]) |=> st_ba[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));

        p_hold_ab_r7: assert property (@(posedge clk) disable iff (rst)
            !$rose(tick_ab[h]) |=> $stable(st_ab[h*HALF_W +: HALF_W]));

        p_hold_ba_r7: assert property (@(posedge clk) disable iff (rst)
            !$rose(tick_ba[h]) |=> $stable(st_ba[h*HALF_W +: HALF_W]));
    end
endmodule

bind bxcv_top bxcv_checker #(.HALF_W(HALF_W), .N_HALVES(N_HALVES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .tick_ab (tick_ab),
    .tick_ba (tick_ba),
    .a_in    (a_in),
    .b_in    (b_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .st_ab   (st_ab),
    .st_ba   (st_ba)
);

// File: tb/bxcv_top_test.sv
`timescale 1ns/1ps
module bxcv_top_test;
    localparam int W  = 8;
    localparam int NH = 2;
    localparam int BW = W * NH;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic [NH-1:0] oe_n = '1, dir = '0, sel_ab = '0, sel_ba = '0, tick_ab = '0, tick_ba = '0;
    logic [BW-1:0] a_in = '0, b_in = '0;
    logic [BW-1:0] a_out, b_out;
    logic [NH-1:0] a_oe, b_oe;

    // staged values, applied by the driver at the falling edge
    logic          s_rst = 1'b1;
    logic [NH-1:0] s_oe_n = '1, s_dir = '0, s_sel_ab = '0, s_sel_ba = '0, s_tick_ab = '0, s_tick_ba = '0;
    logic [BW-1:0] s_a = '0, s_b = '0;

    bxcv_top #(.HALF_W(W), .N_HALVES(NH)) uut (
        .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .tick_ab(tick_ab), .tick_ba(tick_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct {
        logic [BW-1:0] a_out;
        logic [BW-1:0] b_out;
        logic [NH-1:0] a_oe;
        logic [NH-1:0] b_oe;
        string         tag;
    } exp_t;

    exp_t sb[$];

    // bench model of stored words and previous strobe samples
    logic [W-1:0]  m_ab [NH];
    logic [W-1:0]  m_ba [NH];
    logic [NH-1:0] m_pab, m_pba;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    task automatic step(input string tag);
        exp_t e;
        @(negedge clk);
        rst = s_rst; oe_n = s_oe_n; dir = s_dir; sel_ab = s_sel_ab; sel_ba = s_sel_ba;
        tick_ab = s_tick_ab; tick_ba = s_tick_ba; a_in = s_a; b_in = s_b;
        e.a_out = '0; e.b_out = '0; e.a_oe = '0; e.b_oe = '0; e.tag = tag;
        for (int h = 0; h < NH; h++) begin
            if (!s_oe_n[h] && s_dir[h]) begin
                e.b_oe[h] = 1'b1;
                e.b_out[h*W +: W] = s_sel_ab[h] ? m_ab[h] : s_a[h*W +: W];
            end
            if (!s_oe_n[h] && !s_dir[h]) begin
                e.a_oe[h] = 1'b1;
                e.a_out[h*W +: W] = s_sel_ba[h] ? m_ba[h] : s_b[h*W +: W];
            end
        end
        if (!s_rst) sb.push_back(e);
        @(posedge clk);
        for (int h = 0; h < NH; h++) begin
            if (s_rst) begin
                m_ab[h] = '0;
                m_ba[h] = '0;
            end else begin
                if (s_tick_ab[h] && !m_pab[h]) m_ab[h] = s_a[h*W +: W];
                if (s_tick_ba[h] && !m_pba[h]) m_ba[h] = s_b[h*W +: W];
            end
        end
        m_pab = s_tick_ab;
        m_pba = s_tick_ba;
    endtask

    // monitor: pops expected items and compares a moment after inputs settle
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_chk++;
                if (a_out !== e.a_out || b_out !== e.b_out || a_oe !== e.a_oe || b_oe !== e.b_oe) begin
                    n_bad++;
                    $display("FAIL %s: a_out=%h b_out=%h a_oe=%b b_oe=%b expected a_out=%h b_out=%h a_oe=%b b_oe=%b",
                             e.tag, a_out, b_out, a_oe, b_oe, e.a_out, e.b_out, e.a_oe, e.b_oe);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int h = 0; h < NH; h++) begin
            m_ab[h] = 'x;
            m_ba[h] = 'x;
        end
        m_pab = '0; m_pba = '0;
        step("reset"); step("reset"); step("reset");

        // R1: stored paths show zero; half 0 drives B, half 1 drives A
        s_rst = 0; s_oe_n = 2'b00; s_dir = 2'b01; s_sel_ab = 2'b11; s_sel_ba = 2'b11;
        s_a = 16'hFFFF; s_b = 16'hFFFF;
        step("R1");
        s_dir = 2'b10; step("R1");

        // R4: live paths with two patterns
        s_sel_ab = 2'b00; s_sel_ba = 2'b00; s_dir = 2'b11; s_a = 16'h1234; step("R4");
        s_a = 16'hBEEF; step("R4");
        s_dir = 2'b00; s_b = 16'h5A0F; step("R4");

        // R6 / R5: capture A on a strobe rise, show through stored path
        s_dir = 2'b11; s_sel_ab = 2'b11; s_a = 16'hA5C3; s_tick_ab = 2'b11; step("R6");
        s_a = 16'h0000; step("R7"); // held high: no new capture
        s_tick_ab = 2'b00; s_a = 16'h7777; step("R7"); // falling: none
        step("R5");

        // R3: direction decode on both halves
        s_dir = 2'b01; s_sel_ab = 2'b00; s_a = 16'h1111; s_b = 16'h2222; step("R3");
        s_dir = 2'b10; step("R3");

        // R2 / R8: isolated, both strobes rise in both halves
        s_oe_n = 2'b11; s_a = 16'hC0DE; s_b = 16'hF00D; s_tick_ab = 2'b11; s_tick_ba = 2'b11;
        step("R2");
        s_a = 16'h0101; s_b = 16'h0202; s_tick_ab = 2'b00; s_tick_ba = 2'b00; step("R2");
        s_oe_n = 2'b00; s_dir = 2'b11; s_sel_ab = 2'b11; step("R8");
        s_dir = 2'b00; s_sel_ba = 2'b11; step("R8");

        // R8: capture B-side while driving A, capture A-side while driving B
        s_b = 16'h3C3C; s_tick_ba = 2'b11; step("R8");
        s_tick_ba = 2'b00; step("R8");
        s_dir = 2'b11; s_a = 16'h9696; s_tick_ab = 2'b11; step("R8");
        s_tick_ab = 2'b00; step("R8");

        // R9: halves differ: half 0 captures and drives B stored, half 1 isolated
        s_oe_n = 2'b10; s_dir = 2'b01; s_sel_ab = 2'b01; s_a = 16'h4321; s_tick_ab = 2'b01;
        step("R9");
        s_tick_ab = 2'b00; step("R9");
        s_oe_n = 2'b00; s_dir = 2'b11; s_sel_ab = 2'b11; step("R9");

        // R5: switch between live and stored across cycles
        s_a = 16'hEEEE; s_sel_ab = 2'b00; step("R5");
        s_sel_ab = 2'b11; step("R5");
        s_sel_ab = 2'b10; step("R5");

        // R7: strobe held high through reset release causes no capture
        s_rst = 1; s_tick_ab = 2'b11; s_a = 16'hDEAD; step("reset");
        s_rst = 0; s_a = 16'hCAFE; s_sel_ab = 2'b11; step("R7");
        step("R1");
        s_tick_ab = 2'b00; step("R7");
        s_tick_ab = 2'b11; step("R6");
        step("R6");

        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule